// File: doc/BRIEF.md
# Segmented Memory Address Generator

This block converts a logical segment:offset reference into a physical byte address. A request names its access class (instruction fetch, data or stack), can carry a segment override, and gives a 16-bit offset. The block picks one of four segment register values from that information and forms the address in one of two ways, depending on the mode input.

In real mode the chosen 16-bit segment value is scaled by sixteen and added to the offset. The result is a 20-bit address, and several segment:offset pairs can name the same byte. In protected mode the chosen segment value is a selector. The selector picks an entry from a small on-block descriptor store that has a global bank and a local bank. The entry's 24-bit base is added to the offset. The entry's limit and privilege ring are checked, and a failed check raises a fault. A write port loads the descriptor store. Each result is registered and appears one cycle after the request, together with a valid strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: In real mode (prot_mode=0) out_addr equals (segment*16 + offset) modulo 2^20, zero-extended to 24 bits, and out_fault is 0.
- R2: A real-mode sum that carries beyond bit 19 wraps. FFFF:FFFF gives 0FFEFh, and A000:5677 and A111:4567 both give A5677h.
- R3: The default segment depends on req_kind: 0 (fetch) uses seg_cs, 1 (data) uses seg_ds, 2 (stack) uses seg_ss, and 3 behaves like data.
- R4: When ovr_en=1 on a data access (req_kind 1 or 3), ovr_seg picks the segment: 0 = seg_cs, 1 = seg_ds, 2 = seg_ss, 3 = seg_es. Fetch and stack accesses ignore the override.
- R5: In protected mode the selector has its index in bits 15:3, its bank in bit 2 (0 global, 1 local) and its requested ring in bits 1:0. Each bank holds 8 entries, and an index above 7 faults.
- R6: In protected mode a request that does not fault gives out_addr = (base + offset) modulo 2^24.
- R7: In protected mode, an offset greater than the entry's limit faults.
- R8: In protected mode, the request faults when max(cur_priv, requested ring) is numerically greater than the entry's ring.
- R9: out_valid is high exactly one cycle after a cycle with req_valid high. out_addr and out_fault carry that request's result. A faulting result has out_addr = 0.
- R10: After reset, out_valid, out_addr and out_fault are 0, and every descriptor has base 0, limit 0 and ring 0.
- R11: A descriptor write (dw_en) to bank dw_tbl, entry dw_idx, takes effect for requests in later cycles and leaves the other bank unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Access class: 0 fetch, 1 data, 2 stack, 3 data |
| ovr_en | input | 1 | Override requested |
| ovr_seg | input | 2 | Override segment: 0 CS, 1 DS, 2 SS, 3 ES |
| offset | input | 16 | Offset within segment |
| prot_mode | input | 1 | 0 real mode, 1 protected mode |
| cur_priv | input | 2 | Current privilege ring |
| seg_cs | input | 16 | Code segment value or selector |
| seg_ds | input | 16 | Data segment value or selector |
| seg_ss | input | 16 | Stack segment value or selector |
| seg_es | input | 16 | Extra segment value or selector |
| dw_en | input | 1 | Descriptor write enable |
| dw_tbl | input | 1 | Descriptor bank to write: 0 global, 1 local |
| dw_idx | input | 3 | Descriptor entry to write |
| dw_base | input | 24 | Base written |
| dw_limit | input | 16 | Limit written |
| dw_dpl | input | 2 | Privilege ring written |
| out_valid | output | 1 | Result strobe |
| out_addr | output | 24 | Physical address (0 on fault) |
| out_fault | output | 1 | Fault flag |

## Verification
Real-mode address formation is swept over a 64 by 64 grid of segment and offset values. The grid includes sums that carry past bit 19 and the pair of aliasing references, which separates a wrapping adder from one that keeps the carry. Segment choice is tried for every access class, override enable and override code. Each segment register holds a distinct value, so choosing the wrong register shows up directly in the address. In protected mode, both banks are loaded with distinct entries. The sweep then covers every in-range and out-of-range index, every combination of requested and current ring, and offsets at zero, at the limit, one past the limit and at the top. This separates the limit, privilege and index checks from one another, and it exercises a base that wraps past 24 bits.

// File: rtl/segaddr_pkg.sv
package segaddr_pkg;

    localparam int OFF_W     = 16;
    localparam int SEG_W     = 16;
    localparam int REAL_W    = 20;
    localparam int PHYS_W    = 24;
    localparam int PRIV_W    = 2;
    localparam int SEL_IDX_W = SEG_W - 3;
    localparam int NUM_SEGS  = 4;

    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_DATA  = 2'd1,
        ACC_STACK = 2'd2,
        ACC_DATA2 = 2'd3
    } acc_kind_e;

    typedef enum logic [1:0] {
        SR_CS = 2'd0,
        SR_DS = 2'd1,
        SR_SS = 2'd2,
        SR_ES = 2'd3
    } seg_id_e;

    typedef struct packed {
        logic [PHYS_W-1:0] base;
        logic [OFF_W-1:0]  limit;
        logic [PRIV_W-1:0] ring;
    } desc_t;

    typedef struct packed {
        logic [SEL_IDX_W-1:0] index;
        logic                 tbl;
        logic [PRIV_W-1:0]    rpl;
    } selector_t;

    typedef struct packed {
        logic              fault;
        logic [PHYS_W-1:0] addr;
    } result_t;

    function automatic logic [PHYS_W-1:0] real_linear(
        input logic [SEG_W-1:0] seg,
        input logic [OFF_W-1:0] off
    );
        logic [REAL_W-1:0] sum;
        sum = {seg, 4'b0000} + REAL_W'(off);
        return PHYS_W'(sum);
    endfunction

    function automatic logic [PRIV_W-1:0] priv_max(
        input logic [PRIV_W-1:0] a,
        input logic [PRIV_W-1:0] b
    );
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seg_select.sv
module seg_select
    import segaddr_pkg::*;
(
    input  acc_kind_e                      kind,
    input  logic                           ovr_en,
    input  seg_id_e                        ovr_seg,
    input  logic [NUM_SEGS-1:0][SEG_W-1:0] segs,
    output seg_id_e                        chosen,
    output logic [SEG_W-1:0]               seg_val
);

    logic is_data;

    always_comb begin
        is_data = (kind == ACC_DATA) || (kind == ACC_DATA2);
        unique case (kind)
            ACC_FETCH: chosen = SR_CS;
            ACC_STACK: chosen = SR_SS;
            default:   chosen = (ovr_en) ? ovr_seg : SR_DS;
        endcase
        seg_val = segs[chosen];
    end

    always_comb begin
        if (kind == ACC_FETCH)
            a_fetch_uses_cs_r3: assert (chosen == SR_CS);
        if (kind == ACC_STACK)
            a_stack_ignores_ovr_r4: assert (chosen == SR_SS);
        if (is_data && !ovr_en)
            a_data_default_ds_r3: assert (chosen == SR_DS);
    end

endmodule

// File: rtl/desc_store.sv
module desc_store
    import segaddr_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_tbl,
    input  logic [IDX_W-1:0] wr_idx,
    input  desc_t            wr_desc,
    input  logic             rd_tbl,
    input  logic [IDX_W-1:0] rd_idx,
    output desc_t            rd_desc
);

    desc_t bank_q [2][NUM_DESC];
    desc_t bank_rd [2];

    for (genvar t = 0; t < 2; t++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < NUM_DESC; i++) bank_q[t][i] <= '0;
            end else if (wr_en && (wr_tbl == 1'(t))) begin
                bank_q[t][wr_idx] <= wr_desc;
            end
        end
        assign bank_rd[t] = bank_q[t][rd_idx];
    end

    assign rd_desc = rd_tbl ? bank_rd[1] : bank_rd[0];

    p_write_lands_r11: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en) && !$past(rst) && rd_tbl == $past(wr_tbl) && rd_idx == $past(wr_idx))
            |-> rd_desc == $past(wr_desc));

endmodule

// File: rtl/addr_calc.sv
module addr_calc
    import segaddr_pkg::*;
#(
    parameter int NUM_DESC = 8
) (
    input  logic              prot_mode,
    input  logic [SEG_W-1:0]  seg_val,
    input  logic [OFF_W-1:0]  off,
    input  logic [PRIV_W-1:0] cur_priv,
    input  desc_t             desc,
    output result_t           res
);

    selector_t sel;
    logic      idx_bad, lim_bad, priv_bad;

    always_comb begin
        sel      = selector_t'(seg_val);
        idx_bad  = sel.index > SEL_IDX_W'(NUM_DESC - 1);
        lim_bad  = off > desc.limit;
        priv_bad = priv_max(cur_priv, sel.rpl) > desc.ring;
        if (!prot_mode) begin
            res.fault = 1'b0;
            res.addr  = real_linear(seg_val, off);
        end else begin
            res.fault = idx_bad || lim_bad || priv_bad;
            res.addr  = res.fault ? '0 : desc.base + PHYS_W'(off);
        end
    end

endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import segaddr_pkg::*;
#(
    parameter int NUM_DESC = 8,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              ovr_en,
    input  logic [1:0]        ovr_seg,
    input  logic [OFF_W-1:0]  offset,
    input  logic              prot_mode,
    input  logic [PRIV_W-1:0] cur_priv,
    input  logic [SEG_W-1:0]  seg_cs,
    input  logic [SEG_W-1:0]  seg_ds,
    input  logic [SEG_W-1:0]  seg_ss,
    input  logic [SEG_W-1:0]  seg_es,
    input  logic              dw_en,
    input  logic              dw_tbl,
    input  logic [IDX_W-1:0]  dw_idx,
    input  logic [PHYS_W-1:0] dw_base,
    input  logic [OFF_W-1:0]  dw_limit,
    input  logic [PRIV_W-1:0] dw_dpl,
    output logic              out_valid,
    output logic [PHYS_W-1:0] out_addr,
    output logic              out_fault
);

    logic [NUM_SEGS-1:0][SEG_W-1:0] segs;
    seg_id_e          chosen;
    logic [SEG_W-1:0] seg_val;
    selector_t        sel;
    desc_t            wr_desc, rd_desc;
    result_t          res;

    assign segs[SR_CS] = seg_cs;
    assign segs[SR_DS] = seg_ds;
    assign segs[SR_SS] = seg_ss;
    assign segs[SR_ES] = seg_es;

    seg_select u_sel (
        .kind    (acc_kind_e'(req_kind)),
        .ovr_en  (ovr_en),
        .ovr_seg (seg_id_e'(ovr_seg)),
        .segs    (segs),
        .chosen  (chosen),
        .seg_val (seg_val)
    );

    assign sel     = selector_t'(seg_val);
    assign wr_desc = '{base: dw_base, limit: dw_limit, ring: dw_dpl};

    desc_store #(.NUM_DESC(NUM_DESC)) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (dw_en),
        .wr_tbl  (dw_tbl),
        .wr_idx  (dw_idx),
        .wr_desc (wr_desc),
        .rd_tbl  (sel.tbl),
        .rd_idx  (sel.index[IDX_W-1:0]),
        .rd_desc (rd_desc)
    );

    addr_calc #(.NUM_DESC(NUM_DESC)) u_calc (
        .prot_mode (prot_mode),
        .seg_val   (seg_val),
        .off       (offset),
        .cur_priv  (cur_priv),
        .desc      (rd_desc),
        .res       (res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_fault <= 1'b0;
        end else begin
            out_valid <= req_valid;
            if (req_valid) begin
                out_addr  <= res.addr;
                out_fault <= res.fault;
            end
        end
    end

    p_valid_latency_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(req_valid));

    p_fault_zero_addr_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_fault) |-> out_addr == '0);

    p_real_no_fault_r1: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(prot_mode)) |-> (!out_fault && out_addr[PHYS_W-1:REAL_W] == '0));

    p_real_alias_r2: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !$past(prot_mode) && $past(seg_val) == 16'hA000 && $past(offset) == 16'h5677)
            |-> out_addr == 24'h0A5677);

endmodule

// File: tb/seg_addr_gen_tb.sv
module seg_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic        ovr_en;
    logic [1:0]  ovr_seg;
    logic [15:0] offset;
    logic        prot_mode;
    logic [1:0]  cur_priv;
    logic [15:0] seg_cs, seg_ds, seg_ss, seg_es;
    logic        dw_en;
    logic        dw_tbl;
    logic [2:0]  dw_idx;
    logic [23:0] dw_base;
    logic [15:0] dw_limit;
    logic [1:0]  dw_dpl;
    logic        out_valid;
    logic [23:0] out_addr;
    logic        out_fault;

    int n_chk  = 0;
    int n_bad  = 0;
    int cycles = 0;
    bit done   = 0;

    logic [23:0] m_base  [2][8];
    logic [15:0] m_limit [2][8];
    logic [1:0]  m_ring  [2][8];

    always #5 clk = ~clk;

    seg_addr_gen u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .ovr_en(ovr_en), .ovr_seg(ovr_seg), .offset(offset), .prot_mode(prot_mode),
        .cur_priv(cur_priv), .seg_cs(seg_cs), .seg_ds(seg_ds), .seg_ss(seg_ss),
        .seg_es(seg_es), .dw_en(dw_en), .dw_tbl(dw_tbl), .dw_idx(dw_idx),
        .dw_base(dw_base), .dw_limit(dw_limit), .dw_dpl(dw_dpl),
        .out_valid(out_valid), .out_addr(out_addr), .out_fault(out_fault)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            summary();
        end
    end

    // Issue one request at a falling edge; the result is sampled at the next falling edge.
    task automatic issue(input logic [1:0] kind, input logic oe, input logic [1:0] os,
                         input logic [15:0] off, input logic pm, input logic [1:0] cp,
                         output logic [23:0] a, output logic f, output logic v);
        req_valid = 1'b1; req_kind = kind; ovr_en = oe; ovr_seg = os;
        offset = off; prot_mode = pm; cur_priv = cp;
        @(negedge clk);
        a = out_addr; f = out_fault; v = out_valid;
        req_valid = 1'b0;
    endtask

    task automatic write_desc(input logic t, input logic [2:0] i, input logic [23:0] b,
                              input logic [15:0] l, input logic [1:0] r);
        dw_en = 1'b1; dw_tbl = t; dw_idx = i; dw_base = b; dw_limit = l; dw_dpl = r;
        m_base[t][i] = b; m_limit[t][i] = l; m_ring[t][i] = r;
        @(negedge clk);
        dw_en = 1'b0;
    endtask

    function automatic logic [23:0] real_exp(input logic [15:0] s, input logic [15:0] o);
        logic [19:0] sum;
        sum = 20'(({4'b0, s} << 4) + {4'b0, o});
        return {4'b0, sum};
    endfunction

    initial begin
        logic [23:0] a;
        logic f, v;
        logic [15:0] segv [4];
        rst = 1'b1; req_valid = 0; req_kind = 0; ovr_en = 0; ovr_seg = 0; offset = 0;
        prot_mode = 0; cur_priv = 0; seg_cs = 0; seg_ds = 0; seg_ss = 0; seg_es = 0;
        dw_en = 0; dw_tbl = 0; dw_idx = 0; dw_base = 0; dw_limit = 0; dw_dpl = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state of outputs
        check("R10 valid", {31'b0, out_valid}, 0);
        check("R10 addr", {8'b0, out_addr}, 0);
        check("R10 fault", {31'b0, out_fault}, 0);
        // R10: descriptors cleared (limit 0, ring 0, base 0)
        seg_ds = 16'h0000;
        issue(2'd1, 1'b0, 2'd0, 16'h0000, 1'b1, 2'd0, a, f, v);
        check("R10 desc0 addr", {8'b0, a}, 0);
        check("R10 desc0 fault", {31'b0, f}, 0);
        issue(2'd1, 1'b0, 2'd0, 16'h0001, 1'b1, 2'd0, a, f, v);
        check("R10 desc0 limit fault", {31'b0, f}, 1);
        // R9: strobe drops with no request
        @(negedge clk);
        check("R9 idle valid", {31'b0, out_valid}, 0);

        // R2: aliasing pair and wrap
        seg_ds = 16'hA000;
        issue(2'd1, 1'b0, 2'd0, 16'h5677, 1'b0, 2'd0, a, f, v);
        check("R2 alias A000:5677", {8'b0, a}, 32'h0A5677);
        check("R9 valid", {31'b0, v}, 1);
        seg_ds = 16'hA111;
        issue(2'd1, 1'b0, 2'd0, 16'h4567, 1'b0, 2'd0, a, f, v);
        check("R2 alias A111:4567", {8'b0, a}, 32'h0A5677);
        seg_ds = 16'hFFFF;
        issue(2'd1, 1'b0, 2'd0, 16'hFFFF, 1'b0, 2'd0, a, f, v);
        check("R2 wrap FFFF:FFFF", {8'b0, a}, 32'h00FFEF);

        // R1: real-mode grid
        for (int si = 0; si < 64; si++) begin
            for (int oi = 0; oi < 64; oi++) begin
                logic [15:0] s, o;
                s = 16'(si * 16'h0411 + si * 16'h3000);
                o = 16'(oi * 16'h0409 + oi * 16'h0200);
                seg_ds = s;
                issue(2'd1, 1'b0, 2'd0, o, 1'b0, 2'd0, a, f, v);
                check("R1 real addr", {8'b0, a}, {8'b0, real_exp(s, o)});
                check("R1 real fault", {31'b0, f}, 0);
            end
        end

        // R3/R4: segment choice
        segv[0] = 16'h1111; segv[1] = 16'h2222; segv[2] = 16'h3333; segv[3] = 16'h4444;
        seg_cs = segv[0]; seg_ds = segv[1]; seg_ss = segv[2]; seg_es = segv[3];
        for (int k = 0; k < 4; k++) begin
            for (int e = 0; e < 2; e++) begin
                for (int os = 0; os < 4; os++) begin
                    int pick;
                    if (k == 0) pick = 0;
                    else if (k == 2) pick = 2;
                    else pick = (e == 1) ? os : 1;
                    issue(2'(k), 1'(e), 2'(os), 16'h0005, 1'b0, 2'd0, a, f, v);
                    check((e == 1) ? "R4 override choice" : "R3 default choice",
                          {8'b0, a}, {8'b0, real_exp(segv[pick], 16'h0005)});
                end
            end
        end

        // R11: load both banks with distinct entries
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 8; i++) begin
                logic [23:0] b;
                logic [15:0] l;
                b = (t == 1 && i == 7) ? 24'hFFFF00 : 24'((t * 8 + i) * 24'h0A3B1D + 24'h00F0F0);
                l = (i == 7) ? 16'hFFFF : 16'(i * 16'h1234 + 16'h0100);
                write_desc(1'(t), 3'(i), b, l, 2'((i + t) % 4));
            end
        end
        // R11: rewrite one local entry, global twin must stay
        write_desc(1'b1, 3'd3, 24'h123456, 16'h0800, 2'd3);
        seg_ds = 16'({13'd3, 1'b0, 2'd0});
        issue(2'd1, 1'b0, 2'd0, 16'h0000, 1'b1, 2'd0, a, f, v);
        check("R11 global unchanged", {8'b0, a}, {8'b0, m_base[0][3]});
        seg_ds = 16'({13'd3, 1'b1, 2'd0});
        issue(2'd1, 1'b0, 2'd0, 16'h0010, 1'b1, 2'd0, a, f, v);
        check("R11 local rewritten", {8'b0, a}, 32'h123466);

        // R5-R8: protected sweep
        for (int t = 0; t < 2; t++) begin
            for (int i = 0; i < 10; i++) begin
                for (int rp = 0; rp < 4; rp++) begin
                    for (int cp = 0; cp < 4; cp++) begin
                        for (int oc = 0; oc < 4; oc++) begin
                            logic [15:0] o, lim;
                            logic ef;
                            logic [23:0] ea;
                            int eff;
                            lim = (i < 8) ? m_limit[t][i] : 16'h0000;
                            case (oc)
                                0: o = 16'h0000;
                                1: o = lim;
                                2: o = 16'(lim + 16'd1);
                                default: o = 16'hFFFF;
                            endcase
                            eff = (cp > rp) ? cp : rp;
                            if (i >= 8) ef = 1'b1;
                            else ef = (o > m_limit[t][i]) || (eff > int'(m_ring[t][i]));
                            ea = ef ? 24'h0 : 24'(m_base[t][i] + {8'b0, o});
                            seg_ds = 16'({13'(i), 1'(t), 2'(rp)});
                            issue(2'd1, 1'b0, 2'd0, o, 1'b1, 2'(cp), a, f, v);
                            if (i >= 8) check("R5 index fault", {31'b0, f}, {31'b0, ef});
                            else if (o > m_limit[t][i]) check("R7 limit fault", {31'b0, f}, {31'b0, ef});
                            else check("R8 ring fault", {31'b0, f}, {31'b0, ef});
                            check(ef ? "R9 fault addr zero" : "R6 prot addr", {8'b0, a}, {8'b0, ea});
                        end
                    end
                end
            end
        end
        // R6: base wrap past 24 bits, local entry 7
        seg_ds = 16'({13'd7, 1'b1, 2'd0});
        issue(2'd1, 1'b0, 2'd0, 16'hFFFF, 1'b1, 2'd0, a, f, v);
        check("R6 base wrap", {8'b0, a}, 32'h00FEFF);
        // R4: override to ES in protected mode, stack ignores override
        seg_es = 16'({13'd2, 1'b0, 2'd0});
        seg_ss = 16'({13'd5, 1'b0, 2'd0});
        issue(2'd1, 1'b1, 2'd3, 16'h0000, 1'b1, 2'd0, a, f, v);
        check("R4 prot ES override", {8'b0, a}, {8'b0, m_base[0][2]});
        issue(2'd2, 1'b1, 2'd3, 16'h0000, 1'b1, 2'd0, a, f, v);
        check("R4 stack ignores override", {8'b0, a}, {8'b0, m_base[0][5]});
        @(negedge clk);
        summary();
    end

endmodule